// File: doc/BRIEF.md
# Banked ROM and Battery SRAM Window

This block sits on the bus of an 8-bit processor that has a 16-bit address. It opens two 8 kB windows. The lower window, 0x4000-0x5FFF, shows one of sixteen 8 kB pages of an external ROM. The upper window, 0x6000-0x7FFF, shows an external battery-backed 8 kB SRAM. A sixteen-byte I/O hole at 0x7FC0-0x7FCF lies inside the SRAM window. In that hole, one byte reports a firmware switch. The communication registers that would otherwise occupy the hole are not present, so those offsets read as idle values.

No separate register holds the ROM page number. The page is the low nibble of the SRAM byte at offset 0x1FC4, which the processor reaches at 0x7FC4. Any write to that address lands in SRAM like every other write in the window, and the stored nibble selects the page. The block keeps a nibble-wide copy of that byte so that ROM reads need no SRAM access. It refills the copy from SRAM while reset is held, so after every reset the page is whatever the battery memory kept. Reset never forces a page.

Both memories are synchronous, with one cycle of read latency. The processor read result is registered and comes with a one-cycle valid strobe. The block accepts one request per cycle.

Top module: `banked_rom_sram_window`

## Requirements
- R1: A read in 0x4000-0x5FFF drives `rom_addr` = {page, address bits 12:0}, a 17-bit byte address. It returns the ROM byte at page × 0x2000 + (address & 0x1FFF).
- R2: The page is bits 3:0 of the SRAM byte at offset 0x1FC4 (CPU address 0x7FC4). Bits 7:4 of that byte are stored and read back in full, but they have no effect on the page.
- R3: Every write to 0x6000-0x7FFF is stored into SRAM at offset (address & 0x1FFF). This includes writes to the I/O hole 0x7FC0-0x7FCF.
- R4: A read in 0x6000-0x7FFF outside 0x7FC0-0x7FCF returns the SRAM byte at offset (address & 0x1FFF).
- R5: A read in 0x7FC0-0x7FCF is decoded on address bits 3:0. Offset 4 returns the SRAM byte at 0x1FC4. Offset 6 returns 0xFB while `fw_switch` is 1 and 0xFF while it is 0. Every other offset returns 0xFF.
- R6: A read below 0x4000 or at 0x8000 and above returns 0xFF. A write there changes neither the SRAM nor the page.
- R7: While `rst` is 1, the block does not write SRAM. It does read the SRAM byte at offset 0x1FC4, so after reset the page equals the low nibble of that stored byte. `rst` must be held for at least two cycles.
- R8: A read accepted at clock edge k gives `cpu_rvalid` = 1 with its data after edge k+1, for one cycle. A write never raises `cpu_rvalid`. A write to 0x7FC4 sets the page used by a ROM read accepted at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Bus request valid this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Bus address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| cpu_rvalid | output | 1 | Read data valid strobe |
| rom_re | output | 1 | ROM read enable |
| rom_addr | output | 17 | ROM byte address {page, offset} |
| rom_rdata | input | 8 | ROM data, one cycle after `rom_re` |
| sram_re | output | 1 | SRAM read enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 13 | SRAM byte offset |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM data, one cycle after `sram_re` |
| fw_switch | input | 1 | Firmware switch, 1 = active |

## Verification
The bench builds the block with its default parameters: 4 page bits, 13 offset bits and a 4-bit I/O decode. At that size it can sweep all sixteen ROM pages at 65 offsets each, every one of the 8192 SRAM window addresses for writes and reads, and all sixteen I/O offsets with the switch in both states. The SRAM seen at the memory port is an array held in the bench. This lets the bench change the stored page byte during reset, and confirm that the reload comes from memory and not from the last write. It also covers a write to 0x7FC4 followed at once by a ROM read, and the edges of each window, including stray writes that alias to offset 0x1FC4.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  // Source of the byte returned for an accepted read
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_ROM   = 2'd1,
    SRC_SRAM  = 2'd2,
    SRC_CONST = 2'd3
  } rd_src_e;

endpackage

// File: rtl/bwm_decode.sv
module bwm_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned OFS_W     = 13,
  parameter int unsigned IO_W      = 4,
  parameter int unsigned ROM_BASE  = 'h4000,
  parameter int unsigned SRAM_BASE = 'h6000,
  parameter int unsigned IO_BASE   = 'h7FC0,
  parameter int unsigned SEL_IDX   = 4,
  parameter int unsigned SW_IDX    = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_rom,
  output logic              in_sram,
  output logic              in_io,
  output logic              io_sel,
  output logic              io_sw
);

  localparam logic [ADDR_W-1:0] ROM_B  = ADDR_W'(ROM_BASE);
  localparam logic [ADDR_W-1:0] SRAM_B = ADDR_W'(SRAM_BASE);
  localparam logic [ADDR_W-1:0] IO_B   = ADDR_W'(IO_BASE);
  localparam logic [IO_W-1:0]   SEL_I  = IO_W'(SEL_IDX);
  localparam logic [IO_W-1:0]   SW_I   = IO_W'(SW_IDX);

  // Window matches compare only the bits above the window size
  assign in_rom  = (addr[ADDR_W-1:OFS_W] == ROM_B[ADDR_W-1:OFS_W]);
  assign in_sram = (addr[ADDR_W-1:OFS_W] == SRAM_B[ADDR_W-1:OFS_W]);
  assign in_io   = (addr[ADDR_W-1:IO_W]  == IO_B[ADDR_W-1:IO_W]);
  assign io_sel  = in_io && (addr[IO_W-1:0] == SEL_I);
  assign io_sw   = in_io && (addr[IO_W-1:0] == SW_I);

endmodule

// File: rtl/bwm_bank_shadow.sv
module bwm_bank_shadow #(
  parameter int unsigned BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_nib,
  input  logic [BANK_W-1:0] load_nib,
  output logic [BANK_W-1:0] bank
);

  // Delayed reset marks cycles where the fetch of the page byte returns
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
  end

  // The copy carries no reset value: it is refilled from SRAM instead
  always_ff @(posedge clk) begin
    if (wr_en) begin
      bank <= wr_nib;
    end else if (rst_q) begin
      bank <= load_nib;
    end
  end

endmodule

// File: rtl/bwm_read_return.sv
module bwm_read_return
  import bwm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  rd_src_e           issue_src,
  input  logic [DATA_W-1:0] issue_const,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic              s1_valid;
  rd_src_e           s1_src;
  logic [DATA_W-1:0] s1_const;
  logic [DATA_W-1:0] pick;

  // Stage 1 runs alongside the memory access
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_src   <= SRC_NONE;
      s1_const <= '0;
    end else begin
      s1_valid <= issue_valid;
      s1_src   <= issue_src;
      s1_const <= issue_const;
    end
  end

  always_comb begin
    case (s1_src)
      SRC_ROM:  pick = rom_rdata;
      SRC_SRAM: pick = sram_rdata;
      default:  pick = s1_const;
    endcase
  end

  // Stage 2: registered result and strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= s1_valid;
      if (s1_valid) begin
        rdata <= pick;
      end
    end
  end

endmodule

// File: rtl/banked_rom_sram_window.sv
module banked_rom_sram_window
  import bwm_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       BANK_W    = 4,
  parameter int unsigned       OFS_W     = 13,
  parameter int unsigned       IO_W      = 4,
  parameter int unsigned       ROM_BASE  = 'h4000,
  parameter int unsigned       SRAM_BASE = 'h6000,
  parameter int unsigned       IO_BASE   = 'h7FC0,
  parameter int unsigned       SEL_IDX   = 4,
  parameter int unsigned       SW_IDX    = 6,
  parameter logic [DATA_W-1:0] IDLE_VAL  = 'hFF,
  parameter logic [DATA_W-1:0] SW_ON_VAL = 'hFB
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    cpu_rvalid,
  output logic                    rom_re,
  output logic [BANK_W+OFS_W-1:0] rom_addr,
  input  logic [DATA_W-1:0]       rom_rdata,
  output logic                    sram_re,
  output logic                    sram_we,
  output logic [OFS_W-1:0]        sram_addr,
  output logic [DATA_W-1:0]       sram_wdata,
  input  logic [DATA_W-1:0]       sram_rdata,
  input  logic                    fw_switch
);

  localparam int unsigned       ROM_AW   = BANK_W + OFS_W;
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(IO_BASE + SEL_IDX);
  localparam logic [ADDR_W-1:0] SW_ADDR  = ADDR_W'(IO_BASE + SW_IDX);
  localparam logic [ADDR_W-1:0] SRAM_B   = ADDR_W'(SRAM_BASE);
  localparam logic [OFS_W-1:0]  SEL_OFS  = SEL_ADDR[OFS_W-1:0];

  logic              in_rom, in_sram, in_io, io_sel, io_sw;
  logic              rd_req, wr_req;
  logic [BANK_W-1:0] bank;
  rd_src_e           issue_src;
  logic [DATA_W-1:0] issue_const;

  bwm_decode #(
    .ADDR_W   (ADDR_W),
    .OFS_W    (OFS_W),
    .IO_W     (IO_W),
    .ROM_BASE (ROM_BASE),
    .SRAM_BASE(SRAM_BASE),
    .IO_BASE  (IO_BASE),
    .SEL_IDX  (SEL_IDX),
    .SW_IDX   (SW_IDX)
  ) decode_i (
    .addr   (cpu_addr),
    .in_rom (in_rom),
    .in_sram(in_sram),
    .in_io  (in_io),
    .io_sel (io_sel),
    .io_sw  (io_sw)
  );

  // Requests are not taken while reset is held
  assign rd_req = cpu_req && !cpu_we && !rst;
  assign wr_req = cpu_req &&  cpu_we && !rst;

  // Where the byte for this read comes from
  always_comb begin
    issue_src   = SRC_CONST;
    issue_const = IDLE_VAL;
    if (in_rom) begin
      issue_src = SRC_ROM;
    end else if (in_io) begin
      if (io_sel) begin
        issue_src = SRC_SRAM;
      end else if (io_sw && fw_switch) begin
        issue_const = SW_ON_VAL;
      end
    end else if (in_sram) begin
      issue_src = SRC_SRAM;
    end
  end

  bwm_bank_shadow #(
    .BANK_W(BANK_W)
  ) shadow_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_req && io_sel),
    .wr_nib  (cpu_wdata[BANK_W-1:0]),
    .load_nib(sram_rdata[BANK_W-1:0]),
    .bank    (bank)
  );

  // Memory ports; during reset the SRAM port fetches the page byte
  assign rom_re     = rd_req && (issue_src == SRC_ROM);
  assign rom_addr   = {bank, cpu_addr[OFS_W-1:0]};
  assign sram_re    = rst || (rd_req && (issue_src == SRC_SRAM));
  assign sram_we    = wr_req && in_sram;
  assign sram_addr  = rst ? SEL_OFS : cpu_addr[OFS_W-1:0];
  assign sram_wdata = cpu_wdata;

  bwm_read_return #(
    .DATA_W(DATA_W)
  ) ret_i (
    .clk        (clk),
    .rst        (rst),
    .issue_valid(rd_req),
    .issue_src  (issue_src),
    .issue_const(issue_const),
    .rom_rdata  (rom_rdata),
    .sram_rdata (sram_rdata),
    .rdata      (cpu_rdata),
    .rvalid     (cpu_rvalid)
  );

  // R6
  no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_we && (cpu_addr[ADDR_W-1:OFS_W] != SRAM_B[ADDR_W-1:OFS_W]))
      |-> !sram_we);

  // R7
  reset_no_write_chk: assert property (@(posedge clk) rst |-> !sram_we);

  // R8
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_we) |-> ##2 cpu_rvalid);

  // R8
  wr_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_we) |-> ##2 !cpu_rvalid);

  // R2
  page_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cpu_req && cpu_we && (cpu_addr == SEL_ADDR)) && rom_re)
      |-> (rom_addr[ROM_AW-1:OFS_W] == $past(cpu_wdata[BANK_W-1:0])));

  // R5
  sw_status_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_we && (cpu_addr == SW_ADDR) && fw_switch)
      |-> ##2 (cpu_rdata == SW_ON_VAL));

  // R4
  port_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_re, sram_re, sram_we}));

endmodule

// File: tb/banked_rom_sram_window_tb_top.sv
module banked_rom_sram_window_tb_top;

  localparam int OFS_W  = 13;
  localparam int SRAM_N = 1 << OFS_W;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rvalid;
  logic        rom_re;
  logic [16:0] rom_addr;
  logic [7:0]  rom_q;
  logic        sram_re, sram_we;
  logic [12:0] sram_addr;
  logic [7:0]  sram_wdata;
  logic [7:0]  sram_q;
  logic        fw_switch = 1'b0;

  logic [7:0]  mem [SRAM_N];
  bit          seeded = 1'b0;
  logic        poke_en = 1'b0;
  logic [12:0] poke_addr = '0;
  logic [7:0]  poke_val = '0;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] rom_val(input int a);
    return 8'((a * 7 + (a >> 8) * 13 + (a >> 13) * 29) & 255);
  endfunction

  function automatic logic [7:0] seed_val(input int i);
    if (i == 'h1FC4) return 8'hA7;
    return 8'((i * 5 + 3) & 255);
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'((i ^ (i >> 8) ^ 'h5A) & 255);
  endfunction

  function automatic logic [7:0] io_exp(input int off, input logic sw, input logic [7:0] selb);
    if (off == 4) return selb;
    if (off == 6) return sw ? 8'hFB : 8'hFF;
    return 8'hFF;
  endfunction

  // Memory models: synchronous, one-cycle read latency
  always @(posedge clk) begin
    if (!seeded) begin
      for (int i = 0; i < SRAM_N; i++) mem[i] = seed_val(i);
      seeded = 1'b1;
    end else begin
      if (sram_re) sram_q <= mem[sram_addr];
      if (poke_en) mem[poke_addr] = poke_val;
      if (sram_we) mem[sram_addr] = sram_wdata;
    end
    if (rom_re) rom_q <= rom_val(int'(rom_addr));
  end

  banked_rom_sram_window dut_i (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .cpu_rvalid(cpu_rvalid),
    .rom_re    (rom_re),
    .rom_addr  (rom_addr),
    .rom_rdata (rom_q),
    .sram_re   (sram_re),
    .sram_we   (sram_we),
    .sram_addr (sram_addr),
    .sram_wdata(sram_wdata),
    .sram_rdata(sram_q),
    .fw_switch (fw_switch)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string req);
    logic early;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    @(negedge clk);
    cpu_req = 1'b0;
    early = cpu_rvalid;
    @(negedge clk);
    chk(!early && cpu_rvalid && (cpu_rdata == e), req, {early, cpu_rvalid, cpu_rdata}, {2'b01, e});
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = v;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] selb;
    logic [7:0] v;
    logic       seen;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state of outputs, then page comes from the stored byte
    chk(!cpu_rvalid && !sram_we && !rom_re, "R7 idle after reset", {cpu_rvalid, sram_we, rom_re}, 0);
    rd(16'h7FC4, 8'hA7, "R7 page byte after reset");
    rd(16'h4123, rom_val(7 * 8192 + 'h123), "R7 page from stored nibble");

    // R1 R2: all pages, varied upper nibble
    for (int b = 0; b < 16; b++) begin
      v = {4'(b ^ 5), 4'(b)};
      wr(16'h7FC4, v);
      rd(16'h7FC4, v, "R2 full byte readback");
      for (int o = 0; o < 8192; o += 128)
        rd(16'(16'h4000 + o), rom_val(b * 8192 + o), "R1 page read");
      rd(16'h5FFF, rom_val(b * 8192 + 'h1FFF), "R1 top of window");
    end
    wr(16'h7FC4, 8'hF2);
    rd(16'h4040, rom_val(2 * 8192 + 'h40), "R2 upper nibble ignored");

    // R8: write then ROM read at the very next edge
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h7FC4; cpu_wdata = 8'h03;
    @(negedge clk);
    cpu_we = 1'b0; cpu_addr = 16'h4005;
    @(negedge clk);
    cpu_req = 1'b0;
    seen = cpu_rvalid;
    @(negedge clk);
    chk(!seen && cpu_rvalid && cpu_rdata == rom_val(3 * 8192 + 5), "R8 back-to-back page",
        {seen, cpu_rvalid, cpu_rdata}, {2'b01, rom_val(3 * 8192 + 5)});
    @(negedge clk);
    chk(!cpu_rvalid, "R8 single-cycle strobe", cpu_rvalid, 0);
    wr(16'h6001, 8'h77);
    @(negedge clk);
    chk(!cpu_rvalid, "R8 write gives no strobe", cpu_rvalid, 0);

    // R5: I/O hole, both switch states
    selb = 8'h03;
    for (int s = 0; s < 2; s++) begin
      fw_switch = s[0];
      for (int off = 0; off < 16; off++)
        rd(16'(16'h7FC0 + off), io_exp(off, s[0], selb), "R5 io decode");
    end
    fw_switch = 1'b0;

    // R6: outside windows
    rd(16'h0000, 8'hFF, "R6 low read");
    rd(16'h3FFF, 8'hFF, "R6 below rom");
    rd(16'h8000, 8'hFF, "R6 above sram");
    rd(16'hBFC4, 8'hFF, "R6 high read");
    rd(16'hFFFF, 8'hFF, "R6 top read");
    v = 8'(mem['h0000]);
    wr(16'h1FC4, 8'h0E);
    wr(16'h9FC4, 8'h0E);
    wr(16'hFFC4, 8'h0E);
    wr(16'h2000, 8'h11);
    rd(16'h7FC4, 8'h03, "R6 page byte untouched");
    rd(16'h4010, rom_val(3 * 8192 + 'h10), "R6 page untouched");
    rd(16'h6000, v, "R6 sram untouched");

    // R3 R4: full SRAM window
    for (int i = 0; i < SRAM_N; i++) wr(16'(16'h6000 + i), pat(i));
    selb = pat('h1FC4);
    for (int i = 0; i < SRAM_N; i++) begin
      if (i >= 'h1FC0 && i < 'h1FD0)
        rd(16'(16'h6000 + i), io_exp(i & 15, 1'b0, selb), "R5 io after sweep");
      else
        rd(16'(16'h6000 + i), pat(i), "R4 sram read");
    end
    seen = 1'b1;
    for (int i = 'h1FC0; i < 'h1FD0; i++) if (mem[i] != pat(i)) seen = 1'b0;
    chk(seen, "R3 io hole writes stored", seen, 1);
    rd(16'h4777, rom_val(int'(selb[3:0]) * 8192 + 'h777), "R2 page after sweep");

    // R7: second reset reloads from memory, not from last write
    @(negedge clk);
    rst = 1'b1;
    poke_en = 1'b1; poke_addr = 13'h1FC4; poke_val = 8'h5C;
    @(negedge clk);
    poke_en = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    rd(16'h7FC4, 8'h5C, "R7 stored byte kept");
    rd(16'h4100, rom_val(12 * 8192 + 'h100), "R7 reload page");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule